// File: doc/BRIEF.md
# PCI Power Management Capability Register Block

This block holds the eight-byte power management capability of a PCI function and serves it over a simple configuration access port. Each access names a dword index, a byte offset inside that dword, a size of 1, 2 or 4 bytes and, for writes, right-aligned data: the byte at the access offset sits in bits 7:0. The block answers reads of its two dwords and ignores accesses to any other index. The first dword is constant. The second holds the live control/status word.

The block keeps the device power state in the control/status word and sorts it into a class: D0, D3 or unsupported. Each software write that moves the function from one class to another produces a one-cycle event that gives the old and new class. A wake event that arrives while the function is in D3 with wake enabled sets a sticky wake status bit. It also raises a one-cycle wake request. Software clears the status bit by writing a one to it.

Top module: `pm_cap_regs`

## Requirements
- R1: A synchronous reset clears the power state to D0 and clears wake enable and wake status. It loads bit 3 (no soft reset) from `cfg_no_soft_reset`. A read of the control dword then returns this word in bits 15:0, with bits 31:16 at zero.
- R2: A read of dword `CAP_BASE` returns {`CAP_WORD`, `NEXT_PTR`, `CAP_ID`}, which is 0xC8020001 with the default values. Writes to that dword change nothing.
- R3: In the control dword (`CAP_BASE`+1), bits 1:0 hold the power state, bit 3 is no soft reset, bit 8 is wake enable and bit 15 is wake status. Every other bit reads as zero. No write can change bit 3.
- R4: A control-dword write at offset 0 always loads bits 1:0 from data bits 1:0. When the size is 2 or 4, it also loads bit 8 from data bit 8, and data bit 15 acts on wake status.
- R5: A control-dword write at offset 1 with size 1 loads bit 8 from data bit 0, and data bit 7 acts on wake status. It leaves the power state unchanged. The block ignores a write at offset 1 with any other size, any write at offset 2 or 3, and any write to another dword index.
- R6: Writing one to the wake-status position clears wake status. Writing zero leaves it unchanged.
- R7: A `wake_event` sampled while the power state is 3 and wake enable is set does two things: it sets wake status, and `wake_req` goes high for exactly the next cycle. In any other state the event changes nothing and gives no request.
- R8: `pwr_class` reports the current power state with the encoding 0 = D0 (state 0), 1 = D3 (state 3), 2 = unsupported (state 1 or 2).
- R9: When a control-dword write changes the class, `chg_valid` is high for the next cycle, with `chg_from` and `chg_to` coded as in R8. A write that keeps the class, including a move between states 1 and 2, gives no pulse.
- R10: A read request is answered one cycle later: `rd_valid` is high for that cycle and `rd_data` holds the dword. Reads of any other index return zero.
- R11: When a wake event and a control write fall in the same cycle, the wake check uses the word as it stood before the write, and a qualifying wake sets status even if the write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_soft_reset | input | 1 | Reset value of the no-soft-reset bit |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dword | input | IDX_W | Dword index of the access |
| acc_offset | input | 2 | Byte offset inside the dword |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, right-aligned to the offset |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| wake_event | input | 1 | Wake source pulse |
| wake_req | output | 1 | One-cycle wake request |
| pwr_class | output | 2 | Current power-state class |
| chg_valid | output | 1 | Power class changed |
| chg_from | output | 2 | Class before the write |
| chg_to | output | 2 | Class after the write |

## Verification
The assertions assume that `cfg_no_soft_reset` is constant outside reset and that a read and a write never share a cycle; a single `acc_write` flag enforces the second point. They make no assumption about the timing of `wake_event`, which may coincide with any write. The stimulus changes the configuration input only while reset is asserted. It uses sizes 1, 2 and 4, random offsets and indices around the capability, and wake pulses mixed freely into the writes, so the case in R11 arises many times.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
  localparam int CTRL_W   = 16;
  localparam int DATA_W   = 32;
  localparam int ST_MSB   = 1;
  localparam int NSR_POS  = 3;
  localparam int EN_POS   = 8;
  localparam int STS_POS  = 15;

  typedef enum logic [1:0] {
    PWR_D0    = 2'd0,
    PWR_D3    = 2'd1,
    PWR_UNSUP = 2'd2
  } pwr_class_e;

  function automatic pwr_class_e classify(input logic [1:0] st);
    case (st)
      2'd0:    return PWR_D0;
      2'd3:    return PWR_D3;
      default: return PWR_UNSUP;
    endcase
  endfunction
endpackage

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_nsr,
  input  logic              wr_en,
  input  logic [1:0]        wr_off,
  input  logic [2:0]        wr_size,
  input  logic [15:0]       wr_data,
  input  logic              wake_event,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_d,
  output logic              wake_req
);
  logic       hi_upd;
  logic [7:0] hi_byte;
  logic       wake_hit;

  always_comb begin
    ctrl_d  = ctrl_q;
    hi_upd  = 1'b0;
    hi_byte = 8'h00;
    if (wr_en) begin
      if (wr_off == 2'd0) begin
        ctrl_d[ST_MSB:0] = wr_data[ST_MSB:0];
        if (wr_size == 3'd2 || wr_size == 3'd4) begin
          hi_upd  = 1'b1;
          hi_byte = wr_data[15:8];
        end
      end else if (wr_off == 2'd1 && wr_size == 3'd1) begin
        hi_upd  = 1'b1;
        hi_byte = wr_data[7:0];
      end
    end
    if (hi_upd) begin
      if (hi_byte[STS_POS-8]) ctrl_d[STS_POS] = 1'b0;
      ctrl_d[EN_POS] = hi_byte[EN_POS-8];
    end
    wake_hit = wake_event && (ctrl_q[ST_MSB:0] == 2'd3) && ctrl_q[EN_POS];
    if (wake_hit) ctrl_d[STS_POS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q          <= '0;
      ctrl_q[NSR_POS] <= cfg_nsr;
      wake_req        <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      wake_req <= wake_hit;
    end
  end
endmodule

// File: rtl/pm_chg_detect.sv
module pm_chg_detect
  import pm_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [CTRL_W-1:0] ctrl_d,
  output logic              chg_valid,
  output logic [1:0]        chg_from,
  output logic [1:0]        chg_to
);
  pwr_class_e cls_now, cls_nxt;

  always_comb begin
    cls_now = classify(ctrl_q[ST_MSB:0]);
    cls_nxt = classify(ctrl_d[ST_MSB:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_valid <= 1'b0;
      chg_from  <= PWR_D0;
      chg_to    <= PWR_D0;
    end else begin
      chg_valid <= wr_en && (cls_now != cls_nxt);
      chg_from  <= cls_now;
      chg_to    <= cls_nxt;
    end
  end
endmodule

// File: rtl/pm_read_port.sv
module pm_read_port
  import pm_cap_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter logic [7:0]  CAP_ID   = 8'h01,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [15:0] CAP_WORD = 16'hC802
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              hit_cap,
  input  logic              hit_ctrl,
  input  logic [CTRL_W-1:0] ctrl_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] CAP_DWORD = {CAP_WORD, NEXT_PTR, CAP_ID};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (hit_cap)       rd_data <= CAP_DWORD;
        else if (hit_ctrl) rd_data <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        else               rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int             IDX_W    = 6,
  parameter logic [IDX_W-1:0] CAP_BASE = 6'd16,
  parameter logic [7:0]     CAP_ID   = 8'h01,
  parameter logic [7:0]     NEXT_PTR = 8'h00,
  parameter logic [15:0]    CAP_WORD = 16'hC802
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_no_soft_reset,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_dword,
  input  logic [1:0]       acc_offset,
  input  logic [2:0]       acc_size,
  input  logic [31:0]      acc_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic             wake_event,
  output logic             wake_req,
  output logic [1:0]       pwr_class,
  output logic             chg_valid,
  output logic [1:0]       chg_from,
  output logic [1:0]       chg_to
);
  localparam logic [IDX_W-1:0] CTRL_IDX = CAP_BASE + 1'b1;

  logic              hit_cap, hit_ctrl, ctrl_wr, rd_en;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    hit_cap  = (acc_dword == CAP_BASE);
    hit_ctrl = (acc_dword == CTRL_IDX);
    ctrl_wr  = acc_valid && acc_write && hit_ctrl;
    rd_en    = acc_valid && !acc_write;
  end

  pm_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_nsr    (cfg_no_soft_reset),
    .wr_en      (ctrl_wr),
    .wr_off     (acc_offset),
    .wr_size    (acc_size),
    .wr_data    (acc_wdata[15:0]),
    .wake_event (wake_event),
    .ctrl_q     (ctrl_q),
    .ctrl_d     (ctrl_d),
    .wake_req   (wake_req)
  );

  pm_chg_detect u_chg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctrl_wr),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .chg_valid (chg_valid),
    .chg_from  (chg_from),
    .chg_to    (chg_to)
  );

  pm_read_port #(
    .IDX_W    (IDX_W),
    .CAP_ID   (CAP_ID),
    .NEXT_PTR (NEXT_PTR),
    .CAP_WORD (CAP_WORD)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .hit_cap  (hit_cap),
    .hit_ctrl (hit_ctrl),
    .ctrl_q   (ctrl_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_comb pwr_class = classify(ctrl_q[ST_MSB:0]);
endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_no_soft_reset,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        wake_event,
  input logic        wake_req,
  input logic        rd_valid,
  input logic        chg_valid,
  input logic [1:0]  chg_from,
  input logic [1:0]  chg_to,
  input logic [15:0] ctrl_q
);
  p_wake_cond_r7: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(wake_event && ctrl_q[1:0] == 2'd3 && ctrl_q[8]));

  p_wake_sets_status_r11: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ctrl_q[15]);

  p_status_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[15]) |-> wake_req);

  p_nsr_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ctrl_q[3]));

  p_chg_distinct_r9: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> (chg_from != chg_to));

  p_chg_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> $past(acc_valid && acc_write));

  p_rd_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);

  p_rd_only_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));
endmodule

bind pm_cap_regs pm_cap_regs_chk i_chk (
  .clk               (clk),
  .rst               (rst),
  .cfg_no_soft_reset (cfg_no_soft_reset),
  .acc_valid         (acc_valid),
  .acc_write         (acc_write),
  .wake_event        (wake_event),
  .wake_req          (wake_req),
  .rd_valid          (rd_valid),
  .chg_valid         (chg_valid),
  .chg_from          (chg_from),
  .chg_to            (chg_to),
  .ctrl_q            (ctrl_q)
);

// File: tb/test_pm_cap_regs.sv
module test_pm_cap_regs;
  localparam logic [5:0] BASE = 6'd16;
  localparam logic [5:0] CTRL = 6'd17;
  localparam logic [31:0] CAP_DW = 32'hC802_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_nsr = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [5:0]  acc_dword = '0;
  logic [1:0]  acc_offset = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [31:0] acc_wdata = '0;
  logic        wake_event = 1'b0;
  logic        rd_valid, wake_req, chg_valid;
  logic [31:0] rd_data;
  logic [1:0]  pwr_class, chg_from, chg_to;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model;

  always #5 clk = ~clk;

  pm_cap_regs i_pm_cap_regs (
    .clk(clk), .rst(rst), .cfg_no_soft_reset(cfg_nsr),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_dword(acc_dword),
    .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wake_event(wake_event),
    .wake_req(wake_req), .pwr_class(pwr_class), .chg_valid(chg_valid),
    .chg_from(chg_from), .chg_to(chg_to)
  );

  function automatic logic [1:0] cls(input logic [1:0] st);
    return (st == 2'd0) ? 2'd0 : (st == 2'd3) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic wake_ok(input logic [15:0] c, input logic ev);
    return ev && c[1:0] == 2'd3 && c[8];
  endfunction

  function automatic logic [15:0] next_ctrl(input logic [15:0] c, input logic wr,
      input logic [5:0] idx, input logic [1:0] off, input logic [2:0] sz,
      input logic [31:0] d, input logic ev);
    logic [15:0] n;
    logic [7:0]  hb;
    logic        hu;
    n = c; hu = 0; hb = 0;
    if (wr && idx == CTRL) begin
      if (off == 0) begin
        n[1:0] = d[1:0];
        if (sz == 2 || sz == 4) begin hu = 1; hb = d[15:8]; end
      end else if (off == 1 && sz == 1) begin
        hu = 1; hb = d[7:0];
      end
    end
    if (hu) begin
      if (hb[7]) n[15] = 0;
      n[8] = hb[0];
    end
    if (wake_ok(c, ev)) n[15] = 1;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one access/wake cycle, starting and ending at a falling edge
  task automatic op(input logic v, input logic wr, input logic [5:0] idx,
      input logic [1:0] off, input logic [2:0] sz, input logic [31:0] d,
      input logic ev, input string req);
    logic [15:0] n;
    logic [31:0] exp_rd;
    logic        exp_chg, exp_wk;
    n = next_ctrl(model, v && wr, idx, off, sz, d, ev);
    exp_wk  = wake_ok(model, ev);
    exp_chg = v && wr && idx == CTRL && cls(model[1:0]) != cls(n[1:0]);
    exp_rd  = (idx == BASE) ? CAP_DW : (idx == CTRL) ? {16'h0, model} : 32'h0;
    acc_valid = v; acc_write = wr; acc_dword = idx; acc_offset = off;
    acc_size = sz; acc_wdata = d; wake_event = ev;
    @(negedge clk);
    acc_valid = 0; wake_event = 0;
    chk(wake_req == exp_wk, {req, " R7 wake_req"}, 32'(wake_req), 32'(exp_wk));
    chk(chg_valid == exp_chg, {req, " R9 chg_valid"}, 32'(chg_valid), 32'(exp_chg));
    if (exp_chg)
      chk({chg_from, chg_to} == {cls(model[1:0]), cls(n[1:0])}, {req, " R9 from/to"},
          32'({chg_from, chg_to}), 32'({cls(model[1:0]), cls(n[1:0])}));
    if (v && !wr) begin
      chk(rd_valid === 1'b1, {req, " R10 rd_valid"}, 32'(rd_valid), 32'd1);
      chk(rd_data === exp_rd, {req, " R10 rd_data"}, rd_data, exp_rd);
    end else
      chk(rd_valid === 1'b0, {req, " R10 rd_valid idle"}, 32'(rd_valid), 32'd0);
    model = n;
    chk(pwr_class == cls(model[1:0]), {req, " R8 pwr_class"}, 32'(pwr_class), 32'(cls(model[1:0])));
  endtask

  task automatic wr(input logic [5:0] i, input logic [1:0] o, input logic [2:0] s,
      input logic [31:0] d, input string req);
    op(1, 1, i, o, s, d, 0, req);
  endtask
  task automatic rd(input logic [5:0] i, input string req);
    op(1, 0, i, 0, 4, 0, 0, req);
  endtask

  task automatic do_reset(input logic nsr);
    cfg_nsr = nsr; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model = {12'h0, nsr, 3'b0};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    @(negedge clk);
    do_reset(1);
    rd(CTRL, "R1 reset ctrl=0008");
    rd(BASE, "R2 cap dword");
    wr(BASE, 0, 4, 32'hFFFF_FFFF, "R2 write cap ignored");
    rd(BASE, "R2 cap unchanged");
    wr(CTRL, 0, 1, 32'h0000_FFF3, "R4 size1 state only D3");
    rd(CTRL, "R4 expect 000B");
    wr(CTRL, 0, 4, 32'h0000_0008, "R3 nsr not writable");
    rd(CTRL, "R3 nsr kept, others zero");
    wr(CTRL, 0, 1, 32'h3, "R9 back to D3");
    wr(CTRL, 1, 1, 32'h0000_0001, "R5 enable via offset 1");
    rd(CTRL, "R5 expect 010B");
    op(0, 0, 0, 0, 1, 0, 1, "R7 wake in D3 enabled");
    rd(CTRL, "R7 status set 810B");
    wr(CTRL, 0, 2, 32'h0000_0103, "R6 write zero keeps status");
    rd(CTRL, "R6 expect 810B");
    wr(CTRL, 2, 1, 32'hFFFF_FFFF, "R5 offset 2 ignored");
    wr(CTRL, 1, 2, 32'h0000_FFFF, "R5 offset1 size2 ignored");
    wr(CTRL, 3, 1, 32'hFFFF_FFFF, "R5 offset 3 ignored");
    wr(6'd5, 0, 4, 32'h0000_0000, "R5 other index ignored");
    rd(CTRL, "R5 still 810B");
    rd(6'd5, "R10 other index reads zero");
    op(1, 1, CTRL, 1, 1, 32'h81, 1, "R11 wake and clear together");
    rd(CTRL, "R11 status stays set");
    wr(CTRL, 1, 1, 32'h0000_0081, "R6 clear status");
    rd(CTRL, "R6 expect 010B");
    wr(CTRL, 0, 1, 32'h1, "R8 state1 unsupported");
    wr(CTRL, 0, 1, 32'h2, "R9 1 to 2 no pulse");
    op(0, 0, 0, 0, 1, 0, 1, "R7 wake not in D3");
    wr(CTRL, 0, 1, 32'h0, "R9 to D0");
    op(0, 0, 0, 0, 1, 0, 1, "R7 wake in D0");
    rd(CTRL, "R7 no status");
    for (int k = 0; k < 600; k++) begin
      logic [2:0] sz;
      logic [5:0] idx;
      case ($urandom % 3) 0: sz = 1; 1: sz = 2; default: sz = 4; endcase
      case ($urandom % 4) 0: idx = BASE; 3: idx = 6'($urandom); default: idx = CTRL; endcase
      op($urandom % 5 != 0, $urandom % 3 != 0, idx, 2'($urandom), sz, $urandom,
         ($urandom % 3) == 0, "R4 random");
    end
    do_reset(0);
    rd(CTRL, "R1 reset nsr=0");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule